// File: doc/BRIEF.md
# Fly-by DMA Channel Controller

This block is one DMA channel that moves data in single-cycle fly-by fashion. A peripheral raises a request. The channel then masters the system bus for one bus cycle per data item, and drives only one address: the address of the memory or I/O location on the far side. During the same cycle, the acknowledge line tells the requesting peripheral to sink or source the data. The data goes straight from one side to the other and is never held inside the channel.

Software loads a start address and an item count, then chooses the mode. The mode covers:
- the direction;
- one-byte or two-byte items;
- whether the address stays fixed or steps up or down by a programmed amount after each item;
- the bus policy.

Under continuous policy the channel keeps the bus and can finish an item every two clocks. Under intermittent policy it inserts an idle clock after each item, which hands the bus back to the core, so it finishes at most one item every three clocks. When the count runs out, the channel raises a terminal-count flag and a one-clock interrupt pulse. It then stays quiet until it is loaded again.

Top module: `flyby_dma_channel`

## Requirements
- R1: Every data item takes exactly one bus cycle of two clocks. The first clock (T1) drives address and acknowledge. The second clock (T2) also raises `busStrobe`, and the item completes at the end of T2.
- R2: During a bus cycle, `busAddr` carries the channel's address counter. After a load, the counter equals `cfgAddr`.
- R3: `dmaAck` is high on both clocks of every bus cycle, and low outside bus cycles.
- R4: With `dirWrite`=0, the cycle is a read of the addressed location: `busRead`=1 and `busWrite`=0. With `dirWrite`=1, the cycle is a write to it: `busWrite`=1 and `busRead`=0.
- R5: While the request stays high, the T2 clocks of consecutive items are exactly 2 clocks apart with `policyContinuous`=1 and exactly 3 clocks apart with `policyContinuous`=0.
- R6: `itemsLeft` drops by one at the end of each T2.
- R7: After each item, the address counter changes as follows:
  - with `addrUpdate`=0, it stays where it is;
  - with `addrUpdate`=1 and `addrDecrement`=0, it rises by `addrStep`;
  - with `addrUpdate`=1 and `addrDecrement`=1, it falls by `addrStep`.

  This happens whatever the direction and item size.
- R8: During a bus cycle, `busWide` equals `sizeWord`: 1 means two bytes per cycle, 0 means one byte. It is low outside bus cycles.
- R9: When an item leaves `itemsLeft` at zero:
  - `tcFlag` is set from the next clock onward;
  - `tcIrq` is high for exactly that one clock;
  - no further bus cycles start while the request stays high, until a `cfgLoad` clears the flag.
- R10: A bus cycle starts only if, at the clock edge that decides it, all of the following hold:
  - `chEnable` is high;
  - `dmaReq` is high;
  - the count is non-zero.

  A request that falls before that edge starts nothing, and a zero count starts nothing.
- R11: The address counter wraps modulo 2^ADDR_W in both directions.
- R12: After reset, `dmaAck`, `busStrobe`, `tcFlag` and `tcIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Load start address and count, and clear the terminal flag (honoured when idle) |
| cfgAddr | input | ADDR_W | Start address |
| cfgCount | input | CNT_W | Number of items in the block |
| chEnable | input | 1 | Channel enable; gates request recognition |
| dirWrite | input | 1 | 0: read the addressed side; 1: write the addressed side |
| sizeWord | input | 1 | 0: one byte per item; 1: two bytes per item |
| addrUpdate | input | 1 | 1: step the address after each item |
| addrDecrement | input | 1 | 1: step downward; 0: step upward |
| addrStep | input | STEP_W | Address step amount |
| policyContinuous | input | 1 | 1: keep the bus between items; 0: idle clock after each item |
| dmaReq | input | 1 | Request from the implied I/O device |
| dmaAck | output | 1 | Acknowledge to the implied I/O device |
| busAddr | output | ADDR_W | Address counter, driven on the bus during cycles |
| busRead | output | 1 | Read cycle of the addressed side |
| busWrite | output | 1 | Write cycle of the addressed side |
| busStrobe | output | 1 | Data strobe (T2) |
| busWide | output | 1 | Two-byte transfer |
| itemsLeft | output | CNT_W | Remaining item count |
| tcFlag | output | 1 | Terminal count reached |
| tcIrq | output | 1 | One-clock terminal-count pulse |

## Verification
The bench drives every input on a falling edge and samples every output on the falling edge that follows. A request raised at falling edge N therefore gives acknowledge at N+1 and the strobe at N+2.

Later strobes follow at spacings of 2 or 3 falling edges, depending on the policy. At each strobe the bench compares the address with start ± k·step, reduced modulo 2^16.

`itemsLeft` and the address are compared with their stepped values one falling edge after the strobe. The interrupt pulse is counted on the edge after the last strobe. The idle-state checks are made after enough edges that any wrongly started cycle would already be visible.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_T1   = 2'd1,
    ST_T2   = 2'd2,
    ST_REST = 2'd3
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take start address and count, clear terminal state
    logic advance;  // one item finished at end of T2
  } dmaStrobe_t;

endpackage

// File: rtl/flyby_dma_ctrl.sv
module flyby_dma_ctrl
  import flyby_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic       chEnable,
  input  logic       dirWrite,
  input  logic       sizeWord,
  input  logic       policyContinuous,
  input  logic       dmaReq,
  input  logic       countZero,
  input  logic       lastItem,
  input  logic       tcSeen,
  output dmaStrobe_t strobe,
  output logic       dmaAck,
  output logic       busRead,
  output logic       busWrite,
  output logic       busStrobe,
  output logic       busWide
);

  busState_t stateQ, stateD;
  logic      startOk;
  logic      inCycle;

  // a new cycle may start only for an enabled, requesting, unfinished block
  assign startOk = chEnable && dmaReq && !countZero && !tcSeen;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (startOk) stateD = ST_T1;
      ST_T1:   stateD = ST_T2;
      ST_T2: begin
        if (lastItem)              stateD = ST_IDLE;
        else if (!policyContinuous) stateD = ST_REST;
        else if (chEnable && dmaReq) stateD = ST_T1;
        else                       stateD = ST_IDLE;
      end
      ST_REST: stateD = startOk ? ST_T1 : ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign inCycle        = (stateQ == ST_T1) || (stateQ == ST_T2);
  assign strobe.load    = cfgLoad && (stateQ == ST_IDLE);
  assign strobe.advance = (stateQ == ST_T2);

  assign dmaAck    = inCycle;
  assign busRead   = inCycle && !dirWrite;
  assign busWrite  = inCycle && dirWrite;
  assign busStrobe = (stateQ == ST_T2);
  assign busWide   = inCycle && sizeWord;

endmodule

// File: rtl/flyby_dma_datapath.sv
module flyby_dma_datapath
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              addrUpdate,
  input  logic              addrDecrement,
  input  logic [STEP_W-1:0] addrStep,
  output logic [ADDR_W-1:0] addrOut,
  output logic [CNT_W-1:0]  countOut,
  output logic              countZero,
  output logic              lastItem,
  output logic              tcSeen,
  output logic              tcPulse
);

  localparam int PAD_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] addrQ, addrNext, stepWide;
  logic [CNT_W-1:0]  countQ;
  logic              tcQ, irqQ;

  assign stepWide = {{PAD_W{1'b0}}, addrStep};

  // wraps naturally modulo 2^ADDR_W
  always_comb begin
    if (!addrUpdate)        addrNext = addrQ;
    else if (addrDecrement) addrNext = addrQ - stepWide;
    else                    addrNext = addrQ + stepWide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      countQ <= '0;
      tcQ    <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      irqQ <= 1'b0;
      if (strobe.load) begin
        addrQ  <= cfgAddr;
        countQ <= cfgCount;
        tcQ    <= 1'b0;
      end else if (strobe.advance) begin
        addrQ  <= addrNext;
        countQ <= countQ - 1'b1;
        if (countQ == CNT_W'(1)) begin
          tcQ  <= 1'b1;
          irqQ <= 1'b1;
        end
      end
    end
  end

  assign addrOut   = addrQ;
  assign countOut  = countQ;
  assign countZero = (countQ == '0);
  assign lastItem  = (countQ == CNT_W'(1));
  assign tcSeen    = tcQ;
  assign tcPulse   = irqQ;

endmodule

// File: rtl/flyby_dma_channel.sv
module flyby_dma_channel
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              chEnable,
  input  logic              dirWrite,
  input  logic              sizeWord,
  input  logic              addrUpdate,
  input  logic              addrDecrement,
  input  logic [STEP_W-1:0] addrStep,
  input  logic              policyContinuous,
  input  logic              dmaReq,
  output logic              dmaAck,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  output logic              busWrite,
  output logic              busStrobe,
  output logic              busWide,
  output logic [CNT_W-1:0]  itemsLeft,
  output logic              tcFlag,
  output logic              tcIrq
);

  dmaStrobe_t strobe;
  logic       countZero, lastItem;

  flyby_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .chEnable(chEnable),
    .dirWrite(dirWrite), .sizeWord(sizeWord),
    .policyContinuous(policyContinuous), .dmaReq(dmaReq),
    .countZero(countZero), .lastItem(lastItem), .tcSeen(tcFlag),
    .strobe(strobe), .dmaAck(dmaAck), .busRead(busRead),
    .busWrite(busWrite), .busStrobe(busStrobe), .busWide(busWide)
  );

  flyby_dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgAddr(cfgAddr),
    .cfgCount(cfgCount), .addrUpdate(addrUpdate),
    .addrDecrement(addrDecrement), .addrStep(addrStep),
    .addrOut(busAddr), .countOut(itemsLeft), .countZero(countZero),
    .lastItem(lastItem), .tcSeen(tcFlag), .tcPulse(tcIrq)
  );

endmodule

// File: rtl/flyby_dma_checker.sv
module flyby_dma_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic              chEnable,
  input logic              dirWrite,
  input logic              addrUpdate,
  input logic              policyContinuous,
  input logic              dmaReq,
  input logic              dmaAck,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busStrobe,
  input logic              busWrite,
  input logic              busRead,
  input logic [CNT_W-1:0]  itemsLeft,
  input logic              tcFlag,
  input logic              tcIrq
);

  AST_T1_BEFORE_T2: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> $past(dmaAck) && !$past(busStrobe)) else $error("T1 missing"); // R1

  AST_ACK_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> dmaAck) else $error("ack low in T2"); // R3

  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |-> (busWrite == dirWrite) && (busRead == !dirWrite)) else $error("direction"); // R4

  AST_CONT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |=> !busStrobe) else $error("strobe back to back"); // R5

  AST_INT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && !policyContinuous |=> !busStrobe ##1 !busStrobe) else $error("intermittent gap"); // R5

  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    $past(busStrobe) && !$past(cfgLoad) |-> itemsLeft == CNT_W'($past(itemsLeft) - 1'b1)) else $error("count step"); // R6

  AST_ADDR_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    $past(busStrobe) && !$past(addrUpdate) |-> busAddr == $past(busAddr)) else $error("address moved"); // R7

  AST_TC_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    tcIrq |-> tcFlag && !dmaAck) else $error("irq without flag"); // R9

  AST_TC_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    tcFlag |-> !dmaAck) else $error("cycle after terminal count"); // R9

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaAck) |-> $past(chEnable) && $past(dmaReq)) else $error("ungated start"); // R10

endmodule

bind flyby_dma_channel flyby_dma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .chEnable(chEnable),
  .dirWrite(dirWrite), .addrUpdate(addrUpdate),
  .policyContinuous(policyContinuous), .dmaReq(dmaReq), .dmaAck(dmaAck),
  .busAddr(busAddr), .busStrobe(busStrobe), .busWrite(busWrite),
  .busRead(busRead), .itemsLeft(itemsLeft), .tcFlag(tcFlag), .tcIrq(tcIrq)
);

// File: tb/tb_flyby_dma_channel.sv
module tb_flyby_dma_channel;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int STEP_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [CNT_W-1:0] cfgCount = '0;
  logic chEnable = 1'b0, dirWrite = 1'b0, sizeWord = 1'b0;
  logic addrUpdate = 1'b0, addrDecrement = 1'b0;
  logic [STEP_W-1:0] addrStep = '0;
  logic policyContinuous = 1'b0, dmaReq = 1'b0;
  logic dmaAck, busRead, busWrite, busStrobe, busWide, tcFlag, tcIrq;
  logic [ADDR_W-1:0] busAddr;
  logic [CNT_W-1:0] itemsLeft;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgAddr(cfgAddr),
    .cfgCount(cfgCount), .chEnable(chEnable), .dirWrite(dirWrite),
    .sizeWord(sizeWord), .addrUpdate(addrUpdate),
    .addrDecrement(addrDecrement), .addrStep(addrStep),
    .policyContinuous(policyContinuous), .dmaReq(dmaReq), .dmaAck(dmaAck),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busStrobe(busStrobe), .busWide(busWide), .itemsLeft(itemsLeft),
    .tcFlag(tcFlag), .tcIrq(tcIrq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic loadBlock(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n);
    @(negedge clk);
    cfgAddr = a; cfgCount = n; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // one full block with the request held high; every output compared per item
  task automatic runBlock(input bit pol, input bit dir, input bit sz, input bit upd,
                          input bit dec, input int step, input int count);
    logic [ADDR_W-1:0] start, expAddr;
    int strobes, irqs, lastCyc, cyc;
    bit okItem;
    start = dec ? 16'h0001 : 16'hFFFE;   // wraps in both directions (R11)
    policyContinuous = pol; dirWrite = dir; sizeWord = sz;
    addrUpdate = upd; addrDecrement = dec; addrStep = STEP_W'(step);
    loadBlock(start, CNT_W'(count));
    check(busAddr == start && itemsLeft == CNT_W'(count) && !tcFlag, "R2", busAddr, start);
    dmaReq = 1'b1; chEnable = 1'b1;
    strobes = 0; irqs = 0; lastCyc = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      cyc = c;
      if (tcIrq) irqs++;
      if (busStrobe) begin
        expAddr = upd ? (dec ? ADDR_W'(start - ADDR_W'(strobes * step))
                             : ADDR_W'(start + ADDR_W'(strobes * step))) : start;
        okItem = dmaAck && busAddr == expAddr;
        check(okItem, "R2/R3 R7 R11 address", busAddr, expAddr);
        check(busWrite == dir && busRead == !dir, "R4", {busWrite, busRead}, {dir, !dir});
        check(busWide == sz, "R8", busWide, sz);
        if (strobes == 0) check(cyc == 2, "R1 first strobe", cyc, 2);
        else check(cyc - lastCyc == (pol ? 2 : 3), "R5 spacing", cyc - lastCyc, pol ? 2 : 3);
        lastCyc = cyc;
        strobes++;
      end else if (!dmaAck) begin
        check(!busWide && !busRead && !busWrite, "R3/R8 idle bus", {busWide, busRead, busWrite}, 0);
      end
    end
    check(strobes == count, "R9 strobe total", strobes, count);
    check(irqs == 1, "R9 irq pulses", irqs, 1);
    check(tcFlag && itemsLeft == 0, "R6/R9 final", {tcFlag, itemsLeft}, 9'h100);
    expAddr = upd ? (dec ? ADDR_W'(start - ADDR_W'(count * step))
                         : ADDR_W'(start + ADDR_W'(count * step))) : start;
    check(busAddr == expAddr, "R7 R11 final address", busAddr, expAddr);
    dmaReq = 1'b0;
  endtask

  initial begin
    int strobes;
    repeat (3) @(negedge clk);
    check(!dmaAck && !busStrobe && !tcFlag && !tcIrq, "R12 reset",
          {dmaAck, busStrobe, tcFlag, tcIrq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!dmaAck && !tcFlag, "R12 after release", {dmaAck, tcFlag}, 0);

    // sweep: policy x direction x size x {freeze, +1, +3, -1, -3}
    for (int pol = 0; pol < 2; pol++)
      for (int dir = 0; dir < 2; dir++)
        for (int sz = 0; sz < 2; sz++)
          for (int m = 0; m < 5; m++)
            runBlock(pol[0], dir[0], sz[0], m != 0, m >= 3,
                     (m == 2 || m == 4) ? 3 : 1, 3);

    // R10: zero count never starts a cycle
    policyContinuous = 1'b1; addrUpdate = 1'b1; addrDecrement = 1'b0; addrStep = 4'd1;
    loadBlock(16'h0100, 8'd0);
    dmaReq = 1'b1; chEnable = 1'b1; strobes = 0;
    repeat (8) begin @(negedge clk); if (dmaAck) strobes++; end
    check(strobes == 0 && !tcFlag, "R10 zero count", strobes, 0);
    dmaReq = 1'b0;

    // R10: request dropped during first strobe -> block pauses after one item
    loadBlock(16'h0100, 8'd3);
    dmaReq = 1'b1;
    do @(negedge clk); while (!busStrobe);
    dmaReq = 1'b0; strobes = 0;
    repeat (6) begin @(negedge clk); if (dmaAck) strobes++; end
    check(strobes == 0, "R10 request low no cycle", strobes, 0);
    check(itemsLeft == 8'd2 && busAddr == 16'h0101 && !tcFlag, "R6 R7 pause state",
          {itemsLeft, busAddr}, {8'd2, 16'h0101});

    // R10: disabled channel ignores a high request
    chEnable = 1'b0; dmaReq = 1'b1;
    repeat (6) begin @(negedge clk); if (dmaAck) strobes++; end
    check(strobes == 0 && itemsLeft == 8'd2, "R10 disabled", strobes, 0);

    // re-enable: remaining two items complete, then stop while request stays high
    chEnable = 1'b1;
    repeat (12) begin @(negedge clk); if (busStrobe) strobes++; end
    check(strobes == 2 && tcFlag && busAddr == 16'h0103, "R9 resume and stop", strobes, 2);
    strobes = 0;
    repeat (6) begin @(negedge clk); if (dmaAck) strobes++; end
    check(strobes == 0, "R9 held request after terminal count", strobes, 0);

    // reload clears the flag and restarts
    loadBlock(16'h0200, 8'd1);
    check(!tcFlag, "R9 reload clears flag", tcFlag, 0);
    repeat (4) begin @(negedge clk); if (busStrobe) strobes++; end
    check(strobes == 1 && tcFlag, "R9 single item block", strobes, 1);
    dmaReq = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule